// File: doc/BRIEF.md
# Per-Output Clock Divider Selector

This block derives a bank of output clocks from two fast source clocks. Every output lane owns an 8-bit frequency code. The code picks a source clock and a divide ratio, or parks the lane at logic low. Source A is nominally 400 MHz and can be divided by 3, 4, 5, 6 or 12. Source B is nominally 250 MHz and can be divided by 2, 3, 4, 5 or 10. Together the two give ten distinct output frequencies, from 133.3 MHz down to 25 MHz.

Each lane contains one divider engine per source. Each engine has its own synchronized copy of the code. Only one engine drives a lane at a time. On a code change, the engine that is running finishes its current high phase, drops the lane low and releases it. The engine selected by the new code then waits through a low hold before it starts, so no runt pulse reaches the output. Odd ratios use both edges of the source clock to keep the duty cycle at 50 %.

The codes are quasi-static control inputs, for example from a register file. Each code is expected to stay stable for many source cycles between changes.

Top module: `multi_clk_divsel`

## Requirements
- R1: Codes 0x01, 0x03, 0x05, 0x06 and 0x09 make the lane a clock with a period of 3, 4, 5, 6 and 12 source-A cycles respectively.
- R2: Codes 0x02, 0x04, 0x07, 0x08 and 0x0A make the lane a clock with a period of 2, 3, 4, 5 and 10 source-B cycles respectively.
- R3: Code 0x00 holds the lane at logic low with no edges.
- R4: Every code from 0x0B to 0xFF behaves exactly like 0x00: the lane stays low.
- R5: In steady state the high time of a lane equals its low time, which is half its period. This also holds for the odd ratios 3 and 5, which use both source-clock edges.
- R6: After a code change, every high and low pulse on the lane lasts at least the smaller of the old and new half-periods. A lane is never driven by both source engines at once.
- R7: Changing the code of one lane leaves the waveform of every other lane undisturbed.
- R8: While reset is asserted, every lane is low whatever its code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src_a | input | 1 | Source clock A (nominally 400 MHz) |
| clk_src_b | input | 1 | Source clock B (nominally 250 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset for all lanes |
| freq_code | input | NUM_OUT*CODE_W | Per-lane frequency codes; lane i uses bits [i*CODE_W +: CODE_W] |
| clk_out | output | NUM_OUT | Divided output clocks, one bit per lane |

## Verification
A stuck or mis-wrapped divide counter shows up as a wrong high or low time within one output period. A wrong half-count shows up as unequal high and low times on the very next pulse. A failed handoff between the two engines, or a missing low hold, shows up during the first output period after a code change. It appears as a pulse shorter than either half-period, or as a lane high while neither engine claims it. A decode slip on parked codes shows up as the first unexpected edge on a lane that should be quiet. Every edge of every lane is timed against a period model, and parked lanes are sampled on each source-A cycle.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

   localparam int RATIO_W = 4;
   localparam int BASE_CODE_W = 8;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_A    = 2'd1,
      SRC_B    = 2'd2
   } src_e;

   typedef struct packed {
      src_e               src;
      logic [RATIO_W-1:0] ratio;
   } div_sel_t;

   // Maps a frequency code onto a source and a divide ratio.
   function automatic div_sel_t decode_code(input logic [BASE_CODE_W-1:0] code);
      div_sel_t r;
      case (code)
         8'h01: r = '{src: SRC_A, ratio: 4'd3};
         8'h03: r = '{src: SRC_A, ratio: 4'd4};
         8'h05: r = '{src: SRC_A, ratio: 4'd5};
         8'h06: r = '{src: SRC_A, ratio: 4'd6};
         8'h09: r = '{src: SRC_A, ratio: 4'd12};
         8'h02: r = '{src: SRC_B, ratio: 4'd2};
         8'h04: r = '{src: SRC_B, ratio: 4'd3};
         8'h07: r = '{src: SRC_B, ratio: 4'd4};
         8'h08: r = '{src: SRC_B, ratio: 4'd5};
         8'h0A: r = '{src: SRC_B, ratio: 4'd10};
         default: r = '{src: SRC_NONE, ratio: 4'd0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cdv_sync.sv
`timescale 1ns/1ps
module cdv_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cdv_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cdv_code_sync.sv
`timescale 1ns/1ps
module cdv_code_sync #(
   parameter int CODE_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_q
);

   logic [CODE_W-1:0] raw;
   logic [CODE_W-1:0] prev;

   cdv_sync #(.W(CODE_W), .STAGES(STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (code_in),
      .q    (raw)
   );

   // A synchronized code is accepted only once two consecutive samples agree,
   // so a bit-skewed capture of a changing code never reaches the decoder.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev   <= '0;
         code_q <= '0;
      end else begin
         prev <= raw;
         if (raw == prev) code_q <= raw;
      end
   end

endmodule

// File: rtl/cdv_engine.sv
`timescale 1ns/1ps
module cdv_engine
   import clkdiv_pkg::*;
#(
   parameter src_e MY_SRC = SRC_A,
   parameter int   CODE_W = 8,
   parameter int   CNT_W  = RATIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_q,
   input  logic              peer_busy,
   output logic              busy,
   output logic              clk_o
);

   localparam logic [CNT_W-1:0] IDLE_MAX = '1;
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   div_sel_t         sel;
   logic             upper_nz;
   logic             want;
   logic [CNT_W-1:0] want_n, want_k;
   logic [CNT_W-1:0] cur_n, cur_k;
   logic [CNT_W-1:0] cnt, cnt_nxt, idle_cnt;
   logic             run, ph_pos, ph_neg, cur_odd;
   logic             hold, stop_ok, launch;

   generate
      if (CNT_W < RATIO_W) begin : g_bad_cnt
         $error("cdv_engine: CNT_W too narrow for the ratio field");
      end
      if (CODE_W > BASE_CODE_W) begin : g_wide_code
         assign upper_nz = |code_q[CODE_W-1:BASE_CODE_W];
      end else begin : g_base_code
         assign upper_nz = 1'b0;
      end
   endgenerate

   assign sel     = decode_code(code_q[BASE_CODE_W-1:0]);
   assign want    = (sel.src == MY_SRC) && !upper_nz;
   assign want_n  = CNT_W'(sel.ratio);
   assign want_k  = CNT_W'((want_n + ONE) >> 1);
   assign cur_k   = CNT_W'((cur_n + ONE) >> 1);
   assign cnt_nxt = (cnt == cur_n - ONE) ? '0 : cnt + ONE;

   // keep running only while the decoded selection is unchanged
   assign hold    = want && (want_n == cur_n);
   // leaving is allowed once the current high phase is over
   assign stop_ok = !(ph_pos && (cnt_nxt < cur_k));
   // start only after the peer has let go and the low hold has elapsed
   assign launch  = want && !peer_busy && (idle_cnt >= want_k);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         ph_pos   <= 1'b0;
         cnt      <= '0;
         cur_n    <= '0;
         cur_odd  <= 1'b0;
         idle_cnt <= '0;
      end else if (run) begin
         if (!hold && stop_ok) begin
            run      <= 1'b0;
            ph_pos   <= 1'b0;
            cnt      <= '0;
            idle_cnt <= '0;
         end else begin
            cnt    <= cnt_nxt;
            ph_pos <= (cnt_nxt < cur_k);
         end
      end else if (launch) begin
         run     <= 1'b1;
         ph_pos  <= 1'b1;
         cnt     <= '0;
         cur_n   <= want_n;
         cur_odd <= want_n[0];
      end else if (peer_busy) begin
         idle_cnt <= '0;
      end else if (idle_cnt != IDLE_MAX) begin
         idle_cnt <= idle_cnt + ONE;
      end
   end

   // half-cycle delayed copy of the phase, used to trim odd ratios
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) ph_neg <= 1'b0;
      else        ph_neg <= ph_pos;
   end

   assign clk_o = cur_odd ? (ph_pos & ph_neg) : ph_pos;
   assign busy  = run;

endmodule

// File: rtl/cdv_lane.sv
`timescale 1ns/1ps
module cdv_lane
   import clkdiv_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = RATIO_W
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic              clk_o,
   output logic              busy_a,
   output logic              busy_b
);

   logic [CODE_W-1:0] code_qa, code_qb;
   logic              busy_b_in_a, busy_a_in_b;
   logic              out_a, out_b;

   cdv_code_sync #(.CODE_W(CODE_W), .STAGES(SYNC_STAGES)) u_code_a (
      .clk(clk_a), .rst_n(rst_n), .code_in(code), .code_q(code_qa)
   );

   cdv_code_sync #(.CODE_W(CODE_W), .STAGES(SYNC_STAGES)) u_code_b (
      .clk(clk_b), .rst_n(rst_n), .code_in(code), .code_q(code_qb)
   );

   cdv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_busy_b2a (
      .clk(clk_a), .rst_n(rst_n), .d(busy_b), .q(busy_b_in_a)
   );

   cdv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_busy_a2b (
      .clk(clk_b), .rst_n(rst_n), .d(busy_a), .q(busy_a_in_b)
   );

   cdv_engine #(.MY_SRC(SRC_A), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_eng_a (
      .clk      (clk_a),
      .rst_n    (rst_n),
      .code_q   (code_qa),
      .peer_busy(busy_b_in_a),
      .busy     (busy_a),
      .clk_o    (out_a)
   );

   cdv_engine #(.MY_SRC(SRC_B), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_eng_b (
      .clk      (clk_b),
      .rst_n    (rst_n),
      .code_q   (code_qb),
      .peer_busy(busy_a_in_b),
      .busy     (busy_b),
      .clk_o    (out_b)
   );

   // at most one engine is ever active, so the OR cannot merge pulses
   assign clk_o = out_a | out_b;

endmodule

// File: rtl/multi_clk_divsel.sv
`timescale 1ns/1ps
module multi_clk_divsel
   import clkdiv_pkg::*;
#(
   parameter int NUM_OUT     = 15,
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = RATIO_W
) (
   input  logic                      clk_src_a,
   input  logic                      clk_src_b,
   input  logic                      rst_n,
   input  logic [NUM_OUT*CODE_W-1:0] freq_code,
   output logic [NUM_OUT-1:0]        clk_out
);

   logic [NUM_OUT-1:0] lane_busy_a;
   logic [NUM_OUT-1:0] lane_busy_b;

   generate
      if (NUM_OUT < 1) begin : g_bad_num
         $error("multi_clk_divsel: NUM_OUT must be at least 1");
      end
      if (CODE_W < BASE_CODE_W) begin : g_bad_code
         $error("multi_clk_divsel: CODE_W must be at least 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("multi_clk_divsel: SYNC_STAGES must be at least 2");
      end
      if (CNT_W < RATIO_W) begin : g_bad_cnt
         $error("multi_clk_divsel: CNT_W must cover the largest ratio");
      end

      for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
         cdv_lane #(
            .CODE_W     (CODE_W),
            .SYNC_STAGES(SYNC_STAGES),
            .CNT_W      (CNT_W)
         ) u_lane (
            .clk_a (clk_src_a),
            .clk_b (clk_src_b),
            .rst_n (rst_n),
            .code  (freq_code[i*CODE_W +: CODE_W]),
            .clk_o (clk_out[i]),
            .busy_a(lane_busy_a[i]),
            .busy_b(lane_busy_b[i])
         );
      end
   endgenerate

endmodule

// File: rtl/cdv_checker.sv
`timescale 1ns/1ps
module cdv_checker
   import clkdiv_pkg::*;
#(
   parameter int NUM_OUT   = 15,
   parameter int CODE_W    = 8,
   parameter int QUIET_LIM = 48
) (
   input logic                      clk_a,
   input logic                      rst_n,
   input logic [NUM_OUT*CODE_W-1:0] freq_code,
   input logic [NUM_OUT-1:0]        clk_out,
   input logic [NUM_OUT-1:0]        busy_a,
   input logic [NUM_OUT-1:0]        busy_b
);

   localparam int QW = $clog2(QUIET_LIM + 1);
   localparam logic [QW-1:0] QMAX = QW'(QUIET_LIM);

   // R8
   always @(posedge clk_a) begin
      if (!rst_n) begin
         reset_low_chk: assert (clk_out == '0)
            else $error("lane high while reset is asserted");
      end
   end

   generate
      for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
         logic          parked;
         logic [QW-1:0] quiet;

         assign parked = (decode_code(freq_code[g*CODE_W +: BASE_CODE_W]).src == SRC_NONE);

         always_ff @(posedge clk_a or negedge rst_n) begin
            if (!rst_n)               quiet <= '0;
            else if (!parked)         quiet <= '0;
            else if (quiet != QMAX)   quiet <= quiet + 1'b1;
         end

         // R3 R4
         parked_low_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
            (quiet == QMAX) |-> !clk_out[g]);

         // R6
         one_source_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
            !(busy_a[g] && busy_b[g]));

         // R6
         owned_high_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
            clk_out[g] |-> (busy_a[g] || busy_b[g]));
      end
   endgenerate

endmodule

bind multi_clk_divsel cdv_checker #(
   .NUM_OUT(NUM_OUT),
   .CODE_W (CODE_W)
) u_chk (
   .clk_a    (clk_src_a),
   .rst_n    (rst_n),
   .freq_code(freq_code),
   .clk_out  (clk_out),
   .busy_a   (lane_busy_a),
   .busy_b   (lane_busy_b)
);

// File: tb/multi_clk_divsel_tb.sv
`timescale 1ns/1ps
module multi_clk_divsel_tb;

   localparam int N  = 15;
   localparam int CW = 8;

   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic rst_n = 1'b1;
   logic [N*CW-1:0] freq_code = '0;
   logic [N-1:0]    clk_out;

   always #10 clk_a = ~clk_a;   // source A, 20 ns
   always #16 clk_b = ~clk_b;   // source B, 32 ns (8:5 ratio to A)

   multi_clk_divsel u_dut (
      .clk_src_a(clk_a),
      .clk_src_b(clk_b),
      .rst_n    (rst_n),
      .freq_code(freq_code),
      .clk_out  (clk_out)
   );

   int     n_chk = 0;
   int     n_err = 0;
   bit     done  = 0;
   bit     mon_on = 0;
   int     phase = 0;
   int     code_old [N];
   int     code_new [N];
   longint last_t [N];
   int     edges [N];
   bit     seen [N];
   logic [N-1:0] prev_lvl = '0;

   // reference model: expected half-period in ns, 0 for a parked code
   function automatic int half_ns(int c);
      case (c)
         'h01: return 30;  'h03: return 40;  'h05: return 50;
         'h06: return 60;  'h09: return 120;
         'h02: return 32;  'h04: return 48;  'h07: return 64;
         'h08: return 80;  'h0A: return 160;
         default: return 0;
      endcase
   endfunction

   function automatic string code_tag(int c);
      if (c == 'h01 || c == 'h03 || c == 'h05 || c == 'h06 || c == 'h09) return "R1";
      if (c == 'h02 || c == 'h04 || c == 'h07 || c == 'h08 || c == 'h0A) return "R2";
      if (c == 0) return "R3";
      return "R4";
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic set_codes(int c[N]);
      for (int i = 0; i < N; i++) freq_code[i*CW +: CW] = CW'(c[i]);
   endtask

   task automatic start_mon(int o[N], int nw[N]);
      for (int i = 0; i < N; i++) begin
         code_old[i] = o[i];
         code_new[i] = nw[i];
         seen[i]     = 1'b0;
         edges[i]    = 0;
      end
      mon_on = 1'b1;
   endtask

   // steady lanes: edge count, or silence for parked lanes
   task automatic end_checks(bit only_unchanged);
      for (int i = 0; i < N; i++) begin
         if (code_old[i] == code_new[i]) begin
            if (half_ns(code_new[i]) > 0)
               chk(edges[i] >= 4, only_unchanged ? "R7" : code_tag(code_new[i]),
                   $sformatf("lane %0d edge count", i), edges[i], 4);
            else
               chk(edges[i] == 0 && clk_out[i] === 1'b0, code_tag(code_new[i]),
                   $sformatf("lane %0d parked edges", i), edges[i], 0);
         end
      end
   endtask

   // every output edge is timed against the model
   always @(clk_out) begin
      for (int i = 0; i < N; i++) begin
         if (clk_out[i] !== prev_lvl[i]) begin
            if (mon_on) begin
               if (seen[i]) begin
                  longint dur;
                  int     ho, hn, m;
                  bit     was_high;
                  string  tag;
                  dur      = $time - last_t[i];
                  ho       = half_ns(code_old[i]);
                  hn       = half_ns(code_new[i]);
                  was_high = (clk_out[i] === 1'b0);
                  if (code_old[i] == code_new[i]) begin
                     if (ho == 0) begin
                        chk(1'b0, code_tag(code_new[i]), $sformatf("lane %0d edge on parked lane", i), dur, 0);
                     end else begin
                        if (phase == 2)    tag = "R7";
                        else if (was_high) tag = "R5";
                        else               tag = code_tag(code_new[i]);
                        chk(dur == ho, tag,
                            $sformatf("lane %0d %s time", i, was_high ? "high" : "low"), dur, ho);
                     end
                  end else begin
                     if (ho == 0)      m = hn;
                     else if (hn == 0) m = ho;
                     else              m = (ho < hn) ? ho : hn;
                     chk(dur >= m, "R6",
                         $sformatf("lane %0d pulse during code change", i), dur, m);
                  end
               end
               seen[i]   = 1'b1;
               last_t[i] = $time;
               edges[i]++;
            end
            prev_lvl[i] = clk_out[i];
         end
      end
   end

   // parked lanes are compared against the model on every source-A cycle
   always @(negedge clk_a) begin
      if (mon_on) begin
         for (int i = 0; i < N; i++) begin
            if (half_ns(code_old[i]) == 0 && half_ns(code_new[i]) == 0)
               chk(clk_out[i] === 1'b0, code_tag(code_new[i]),
                   $sformatf("lane %0d parked level", i), longint'(clk_out[i]), 0);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      int c1 [N];
      int c2 [N];
      c1 = '{'h01, 'h02, 'h03, 'h04, 'h05, 'h06, 'h07, 'h08, 'h09, 'h0A,
             'h00, 'h0B, 'hFF, 'h03, 'h0A};
      c2 = '{'h0A, 'h01, 'h09, 'h00, 'h05, 'h08, 'h07, 'h02, 'h01, 'h0C,
             'h05, 'h07, 'hFF, 'h03, 'h03};

      // R8: codes already set, reset must dominate
      set_codes(c1);
      #2 rst_n = 1'b0;
      repeat (6) begin
         @(negedge clk_a);
         chk(clk_out === '0, "R8", "outputs during reset", longint'(clk_out), 0);
      end
      #5 rst_n = 1'b1;
      repeat (200) @(negedge clk_a);

      // phase 1: steady waveforms for every code class (R1 R2 R3 R4 R5)
      #3 phase = 1;
      start_mon(c1, c1);
      #3000 mon_on = 1'b0;
      end_checks(1'b0);

      // phase 2: change eleven lanes, four stay put (R6 R7)
      #3 phase = 2;
      start_mon(c1, c2);
      #101 set_codes(c2);
      #4000 mon_on = 1'b0;
      end_checks(1'b1);

      // phase 3: new steady state after the switch
      #3 phase = 3;
      start_mon(c2, c2);
      #3000 mon_on = 1'b0;
      end_checks(1'b0);

      finish_run();
   end

endmodule